// File: doc/BRIEF.md
# Board interrupt level encoder

This block is a small board-control register file on a 16-bit bus. It takes thirteen level-sensitive interrupt request lines from peripherals on the board. Each request goes through its own bit of a software-writable enable mask. The block then reduces all active, enabled requests to one 4-bit encoded interrupt level for the processor. Each request has a fixed priority number from 0 to 12 and a fixed bit position in the 16-bit mask and status space. The bit positions are not contiguous. Of the qualifying requests, the one with the lowest number wins. Its number is driven out XOR 15, so an idle board shows 0 and the most urgent source shows 15.

The block also has a constant version register, a general-purpose output port register and a power-off control. A write to the power-off control with bit 0 set gives a one-cycle shutdown pulse. Register reads are combinational from the address. Writes take effect at the clock edge. The encoded level follows the request lines combinationally and follows the mask from the edge that writes it.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset the mask register and the output port register read 0, irl_o is 0 and poweroff_o is low.
- R2: Request req_i[k] has priority number k. It qualifies when it is high and its mask bit is 1. The mask bit for each k is: 0:11, 1:9, 2:8, 3:12, 4:10, 5:6, 6:5, 7:4, 8:7, 9:14, 10:13, 11:0, 12:15. irl_o equals the lowest qualifying k XOR 15.
- R3: When no request qualifies, the selected level is 15 and irl_o is 0. Mask bits 1, 2 and 3 belong to no source and never qualify a request.
- R4: The mask register at byte offset 0x00 is read/write. irl_o reflects a written mask from the clock edge that performs the write.
- R5: Reading offset 0x32 always returns 0x0010. Writes to 0x32 change nothing.
- R6: Reading offset 0x30 returns 0. A write to 0x30 with bit 0 set makes poweroff_o high for exactly the one cycle after the write edge. A write with bit 0 clear produces no pulse.
- R7: The output port register at 0x36 is read/write, holds its value, and is driven on gpo_o.
- R8: Reads of any other offset return 0. Writes to other offsets change no register.
- R9: Requests act as levels. Dropping a request removes it from the encoding with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 13 | Interrupt requests, bit k has priority number k |
| addr_i | input | 6 | Byte offset of the register access |
| wen_i | input | 1 | Write strobe, one 16-bit write per cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irl_o | output | 4 | Encoded interrupt level, inverted |
| poweroff_o | output | 1 | One-cycle shutdown request |
| gpo_o | output | 16 | Output port register value |

## Verification
The encoder is driven with these patterns:
- All requests against a full mask, which picks out the top priority.
- Single requests against a single matching mask bit, which exposes any wrong bit position.
- Pairs where the mask hides the more urgent source, which shows that masking is applied before the priority choice.
- An empty mask and a mask of only the unused bits, which separate the idle code from level 0.

Directed cases cover:
- Dropping a request with no clock edge in between.
- Writes to the version and unmapped offsets, read back afterwards.
- Power-off writes with bit 0 set and clear, sampled over two cycles to measure the pulse width.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int unsigned NUM_SRC = 13;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned LVL_W   = 4;
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  // Fixed mask/status bit for each priority number
  function automatic int unsigned src_bit(int unsigned lvl);
    case (lvl)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      12: return 15;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/irq_status_map.sv
module irq_status_map
  import board_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned W     = DATA_W
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [W-1:0]     status_o
);
  always_comb begin
    status_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      status_o[src_bit(k)] = req_i[k];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import board_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned W     = DATA_W,
  parameter int unsigned LW    = LVL_W
) (
  input  logic [W-1:0]  status_i,
  input  logic [W-1:0]  mask_i,
  output logic [LW-1:0] irl_o
);
  localparam logic [LW-1:0] IDLE = '1;
  logic [W-1:0]  qual;
  logic [LW-1:0] sel;

  assign qual = status_i & mask_i;

  // scan from low urgency to high so the smallest number wins
  always_comb begin
    sel = IDLE;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (qual[src_bit(k)]) sel = LW'(k);
    end
  end

  assign irl_o = sel ^ IDLE;
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter int unsigned W      = 16,
  parameter int unsigned AW     = 6,
  parameter logic [AW-1:0] OFS_MASK = 6'h00,
  parameter logic [AW-1:0] OFS_PWR  = 6'h30,
  parameter logic [AW-1:0] OFS_VER  = 6'h32,
  parameter logic [AW-1:0] OFS_GPO  = 6'h36,
  parameter logic [W-1:0]  VERSION  = 16'h0010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wen_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  gpo_o,
  output logic          poweroff_o
);
  logic [W-1:0] mask_q, gpo_q;
  logic         pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gpo_q  <= '0;
      pwr_q  <= 1'b0;
    end else begin
      pwr_q <= wen_i && (addr_i == OFS_PWR) && wdata_i[0];
      if (wen_i && addr_i == OFS_MASK) mask_q <= wdata_i;
      if (wen_i && addr_i == OFS_GPO)  gpo_q  <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_MASK: rdata_o = mask_q;
      OFS_VER:  rdata_o = VERSION;
      OFS_GPO:  rdata_o = gpo_q;
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o     = mask_q;
  assign gpo_o      = gpo_q;
  assign poweroff_o = pwr_q;
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned W     = DATA_W,
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wen_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic [LW-1:0]    irl_o,
  output logic             poweroff_o,
  output logic [W-1:0]     gpo_o
);
  logic [W-1:0] status_w, mask_w;

  irq_status_map #(.N_SRC(N_SRC), .W(W)) u_map (
    .req_i    (req_i),
    .status_o (status_w)
  );

  board_ctrl_regs #(.W(W), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wen_i      (wen_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .mask_o     (mask_w),
    .gpo_o      (gpo_o),
    .poweroff_o (poweroff_o)
  );

  irq_prio_enc #(.N_SRC(N_SRC), .W(W), .LW(LW)) u_enc (
    .status_i (status_w),
    .mask_i   (mask_w),
    .irl_o    (irl_o)
  );
endmodule

// File: rtl/board_irq_ctrl_chk.sv
module board_irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [12:0] req_i,
  input logic [5:0]  addr_i,
  input logic        wen_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic [3:0]  irl_o,
  input logic        poweroff_o,
  input logic [15:0] gpo_o,
  input logic [15:0] mask_w
);
  // R2: priority 0 enabled beats everything
  p_top_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[0] && mask_w[11]) |-> irl_o == 4'd15);

  // R3: no requests gives idle code
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> irl_o == 4'd0);

  // R4: mask only moves on a write to its offset
  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wen_i && addr_i == 6'h00) |=> $stable(mask_w));

  // R5: version constant
  p_version_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 6'h32) |-> rdata_o == 16'h0010);

  // R6: pulse only after a qualifying write
  p_pwr_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poweroff_o |-> $past(wen_i && addr_i == 6'h30 && wdata_i[0]));

  // R7: output port takes the written value
  p_gpo_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && addr_i == 6'h36) |=> gpo_o == $past(wdata_i));

  // R8: unmapped offsets read zero
  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_i inside {6'h00, 6'h32, 6'h36}) |-> rdata_o == 16'h0000);
endmodule

bind board_irq_ctrl board_irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .addr_i     (addr_i),
  .wen_i      (wen_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irl_o      (irl_o),
  .poweroff_o (poweroff_o),
  .gpo_o      (gpo_o),
  .mask_w     (mask_w)
);

// File: tb/board_irq_ctrl_test.sv
`timescale 1ns/1ps
module board_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] req = '0;
  logic [5:0]  addr = '0;
  logic        wen = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irl;
  logic        pwr;
  logic [15:0] gpo;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  board_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wen_i(wen),
    .wdata_i(wdata), .rdata_o(rdata), .irl_o(irl), .poweroff_o(pwr), .gpo_o(gpo)
  );

  // {req[12:0], mask[15:0], expected irl[3:0]}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {13'h0000, 16'hFFFF, 4'd0},
    {13'h1FFF, 16'hFFFF, 4'd15},
    {13'h1FFF, 16'h0000, 4'd0},
    {13'h1FFF, 16'h8000, 4'd3},
    {13'h1000, 16'hFFFF, 4'd3},
    {13'h0800, 16'h0001, 4'd4},
    {13'h0028, 16'hFFFF, 4'd12},
    {13'h0028, 16'h0040, 4'd10},
    {13'h0001, 16'hF7FF, 4'd0},
    {13'h0201, 16'hF7FF, 4'd6},
    {13'h0180, 16'h0090, 4'd8},
    {13'h0400, 16'h2000, 4'd5},
    {13'h0006, 16'h0100, 4'd13},
    {13'h0010, 16'h0400, 4'd11},
    {13'h0040, 16'h0020, 4'd9},
    {13'h1FFF, 16'h000E, 4'd0}
  };

  task automatic chk(string req_tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1;
    @(negedge clk);
    wen = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irl", {12'h0, irl}, 16'h0);
    chk("R1 pwr", {15'h0, pwr}, 16'h0);
    chk("R1 gpo", gpo, 16'h0);
    rst_n = 1;
    bus_rd(6'h00, rv); chk("R1 mask", rv, 16'h0);
    bus_rd(6'h36, rv); chk("R1 gpo rd", rv, 16'h0);

    // R2 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_wr(6'h00, VEC[i][19:4]);
      req = VEC[i][32:20];
      #1 chk("R2 vec", {12'h0, irl}, {12'h0, VEC[i][3:0]});
    end
    bus_rd(6'h00, rv); chk("R4 mask rd", rv, 16'h000E);

    // R4 mask effect at write edge
    req = 13'h0002;
    #1 chk("R3 unused bits", {12'h0, irl}, 16'h0);
    @(negedge clk);
    addr = 6'h00; wdata = 16'h0200; wen = 1;
    @(posedge clk); #1;
    chk("R4 edge", {12'h0, irl}, 16'd14);
    @(negedge clk); wen = 0;

    // R9 drop request without clock
    req = 13'h0003;
    #1 chk("R9 up", {12'h0, irl}, 16'd14);
    req = 13'h0000;
    #1 chk("R9 drop", {12'h0, irl}, 16'd0);

    // R5 version
    bus_rd(6'h32, rv); chk("R5 ver", rv, 16'h0010);
    bus_wr(6'h32, 16'hABCD);
    bus_rd(6'h32, rv); chk("R5 ver wr", rv, 16'h0010);

    // R6 power off
    bus_rd(6'h30, rv); chk("R6 rd", rv, 16'h0);
    bus_wr(6'h30, 16'h0001);
    chk("R6 pulse", {15'h0, pwr}, 16'h1);
    @(negedge clk);
    chk("R6 width", {15'h0, pwr}, 16'h0);
    bus_wr(6'h30, 16'hFFFE);
    chk("R6 bit0 clear", {15'h0, pwr}, 16'h0);

    // R7 output port
    bus_wr(6'h36, 16'h5AA5);
    chk("R7 gpo", gpo, 16'h5AA5);
    repeat (3) @(negedge clk);
    bus_rd(6'h36, rv); chk("R7 hold", rv, 16'h5AA5);

    // R8 other offsets
    bus_wr(6'h02, 16'hFFFF);
    bus_wr(6'h3E, 16'h1234);
    bus_rd(6'h02, rv); chk("R8 rd", rv, 16'h0);
    bus_rd(6'h34, rv); chk("R8 rd2", rv, 16'h0);
    bus_rd(6'h00, rv); chk("R8 mask kept", rv, 16'h0200);
    chk("R8 gpo kept", gpo, 16'h5AA5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule